// File: doc/BRIEF.md
# Indexed Chipset Configuration Port

This block is a byte-wide configuration register file for a legacy chipset, reached through a pair of I/O ports. Software first writes a register number to the index port. It then reads or writes the chosen byte through the data port. The selected register number stays in place until software rewrites it, so any number of data accesses can follow one index write.

Every register bit drives the downstream chipset logic through one flat output vector. Some writes also raise side-effect signals for neighbouring logic:

- A write to the wait-state register raises a one-cycle request to recompute CPU wait states.
- A write to any of the four shadow-control registers raises a one-cycle request to rebuild the shadow memory map.
- One bit of the miscellaneous-control register is brought out as a level that enables the fast-reset/A20 system control port.

The bus side is a simple synchronous strobe interface. A write is captured on the clock edge where the write enable is high. Read data is combinational and is valid in the same cycle as the read enable.

Top module: `cfg_index_port`

## Requirements
- R1: A write to I/O address 0x0022 (the index port) loads the low IDX_W bits of the write data as the current index and leaves every register unchanged.
- R2: A write to I/O address 0x0023 (the data port) stores the write data into the register picked by the current index. The new value is visible on regs_o, at bit offset index*8, after the capturing clock edge.
- R3: While rd_en_i is high and addr_i is 0x0023, rd_data_o shows the register picked by the current index in the same cycle.
- R4: rd_data_o is 0xFF whenever rd_en_i is low or addr_i is anything other than 0x0023, including the index port 0x0022.
- R5: After reset the index is 0, register 0x05 holds 0x05, register 0x1B holds 0x60, and every other register holds 0x00. The three side-effect outputs are low.
- R6: A data-port write while the index is 0x06 drives wait_upd_o high for exactly the one cycle after the capturing edge. No other access raises it, and that includes an index-port write of the value 0x06.
- R7: A data-port write while the index is in 0x18..0x1B inclusive drives shadow_upd_o high for exactly the one cycle after the capturing edge. Writes at any other index leave it low.
- R8: sysctl_en_o equals bit 5 of register 0x1C. It follows each data write to that register from the capturing edge onward, and it is low after reset.
- R9: The index is kept across data-port reads and writes. It changes only on an index-port write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | I/O address of the current access |
| wr_data_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe, one access per high cycle |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Read data, valid in the cycle of rd_en_i |
| regs_o | output | 2048 | All registers, register n at bits n*8+7..n*8 |
| wait_upd_o | output | 1 | One-cycle wait-state recalculation request |
| shadow_upd_o | output | 1 | One-cycle shadow-map rebuild request |
| sysctl_en_o | output | 1 | System control port enable level |

## Verification
Read data is combinational, so the bench samples rd_data_o 1 ns after it raises rd_en_i, within that same cycle. Register contents, sysctl_en_o and both update strobes all change at the edge that captures a write. The bench drives each write on a falling edge and samples these results at the next falling edge, which falls inside the one-cycle strobe window. To confirm that each strobe lasts only one cycle, the bench samples again after one more idle cycle and expects it low.

// File: rtl/cip_pkg.sv
package cip_pkg;

  typedef struct packed {
    logic idx_wr;
    logic dat_wr;
    logic dat_rd;
  } port_hit_t;

  // power-on image of the configuration space
  function automatic logic [7:0] reset_image(input int unsigned idx);
    case (idx)
      5:       return 8'h05;
      27:      return 8'h60;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cip_bus_decode.sv
module cip_bus_decode #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned INDEX_PORT = 16'h0022,
  parameter int unsigned DATA_PORT  = 16'h0023
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  output cip_pkg::port_hit_t hit_o
);

  logic at_index, at_data;

  assign at_index = (addr_i == ADDR_W'(INDEX_PORT));
  assign at_data  = (addr_i == ADDR_W'(DATA_PORT));

  assign hit_o.idx_wr = wr_en_i && at_index;
  assign hit_o.dat_wr = wr_en_i && at_data;
  assign hit_o.dat_rd = rd_en_i && at_data;

endmodule

// File: rtl/cip_reg_file.sv
module cip_reg_file #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 8,
  localparam int unsigned NREGS = 1 << IDX_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    idx_wr_i,
  input  logic                    dat_wr_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  output logic [IDX_W-1:0]        index_o,
  output logic [DATA_W-1:0]       rd_word_o,
  output logic [NREGS*DATA_W-1:0] regs_o
);

  logic [IDX_W-1:0]  index_q;
  logic [DATA_W-1:0] regs_q [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       index_q <= '0;
    else if (idx_wr_i) index_q <= wr_data_i[IDX_W-1:0];
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_q[g] <= DATA_W'(cip_pkg::reset_image(g));
      else if (dat_wr_i && index_q == IDX_W'(g))
        regs_q[g] <= wr_data_i;
    end
    assign regs_o[g*DATA_W +: DATA_W] = regs_q[g];
  end

  assign index_o   = index_q;
  assign rd_word_o = regs_q[index_q];

endmodule

// File: rtl/cip_side_fx.sv
module cip_side_fx #(
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned WAIT_IDX  = 8'h06,
  parameter int unsigned SHADOW_LO = 8'h18,
  parameter int unsigned SHADOW_HI = 8'h1B
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dat_wr_i,
  input  logic [IDX_W-1:0] index_i,
  output logic             wait_upd_o,
  output logic             shadow_upd_o
);

  logic wait_hit, shadow_hit;

  assign wait_hit   = dat_wr_i && (index_i == IDX_W'(WAIT_IDX));
  assign shadow_hit = dat_wr_i && (index_i >= IDX_W'(SHADOW_LO))
                               && (index_i <= IDX_W'(SHADOW_HI));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_upd_o   <= 1'b0;
      shadow_upd_o <= 1'b0;
    end else begin
      wait_upd_o   <= wait_hit;
      shadow_upd_o <= shadow_hit;
    end
  end

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned INDEX_PORT = 16'h0022,
  parameter int unsigned DATA_PORT  = 16'h0023,
  parameter int unsigned WAIT_IDX   = 8'h06,
  parameter int unsigned SHADOW_LO  = 8'h18,
  parameter int unsigned SHADOW_HI  = 8'h1B,
  parameter int unsigned SYSCTL_IDX = 8'h1C,
  parameter int unsigned SYSCTL_BIT = 5
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  input  logic                             wr_en_i,
  input  logic                             rd_en_i,
  output logic [DATA_W-1:0]                rd_data_o,
  output logic [(1<<IDX_W)*DATA_W-1:0]     regs_o,
  output logic                             wait_upd_o,
  output logic                             shadow_upd_o,
  output logic                             sysctl_en_o
);

  cip_pkg::port_hit_t hit;
  logic [IDX_W-1:0]   cur_idx;
  logic [DATA_W-1:0]  rd_word;

  cip_bus_decode #(
    .ADDR_W(ADDR_W), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)
  ) u_dec (
    .addr_i(addr_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .hit_o(hit)
  );

  cip_reg_file #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .idx_wr_i(hit.idx_wr), .dat_wr_i(hit.dat_wr), .wr_data_i(wr_data_i),
    .index_o(cur_idx), .rd_word_o(rd_word), .regs_o(regs_o)
  );

  cip_side_fx #(
    .IDX_W(IDX_W), .WAIT_IDX(WAIT_IDX),
    .SHADOW_LO(SHADOW_LO), .SHADOW_HI(SHADOW_HI)
  ) u_fx (
    .clk_i(clk_i), .rst_ni(rst_ni), .dat_wr_i(hit.dat_wr), .index_i(cur_idx),
    .wait_upd_o(wait_upd_o), .shadow_upd_o(shadow_upd_o)
  );

  // index port is write-only; idle bus floats high
  assign rd_data_o   = hit.dat_rd ? rd_word : '1;
  assign sysctl_en_o = regs_o[SYSCTL_IDX*DATA_W + SYSCTL_BIT];

endmodule

// File: rtl/cip_checker.sv
module cip_checker #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned INDEX_PORT = 16'h0022,
  parameter int unsigned DATA_PORT  = 16'h0023,
  parameter int unsigned WAIT_IDX   = 8'h06,
  parameter int unsigned SHADOW_LO  = 8'h18,
  parameter int unsigned SHADOW_HI  = 8'h1B,
  parameter int unsigned SYSCTL_IDX = 8'h1C,
  parameter int unsigned SYSCTL_BIT = 5
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [ADDR_W-1:0]            addr_i,
  input logic [DATA_W-1:0]            wr_data_i,
  input logic                         wr_en_i,
  input logic                         rd_en_i,
  input logic [DATA_W-1:0]            rd_data_o,
  input logic [(1<<IDX_W)*DATA_W-1:0] regs_o,
  input logic                         wait_upd_o,
  input logic                         shadow_upd_o,
  input logic                         sysctl_en_o,
  input logic [IDX_W-1:0]             idx_i
);

  logic idx_w, dat_w, in_shadow;
  assign idx_w     = wr_en_i && (addr_i == ADDR_W'(INDEX_PORT));
  assign dat_w     = wr_en_i && (addr_i == ADDR_W'(DATA_PORT));
  assign in_shadow = (idx_i >= IDX_W'(SHADOW_LO)) && (idx_i <= IDX_W'(SHADOW_HI));

  p_index_keeps_regs_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_w |=> $stable(regs_o));

  p_other_read_ff_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i != ADDR_W'(DATA_PORT)) |-> rd_data_o == '1);

  p_wait_fire_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_w && idx_i == IDX_W'(WAIT_IDX)) |=> wait_upd_o);

  p_wait_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dat_w && idx_i == IDX_W'(WAIT_IDX)) |=> !wait_upd_o);

  p_shadow_fire_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_w && in_shadow) |=> shadow_upd_o);

  p_shadow_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dat_w && in_shadow) |=> !shadow_upd_o);

  p_sysctl_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_w && idx_i == IDX_W'(SYSCTL_IDX)) |=> sysctl_en_o == $past(wr_data_i[SYSCTL_BIT]));

  p_index_persist_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idx_w |=> $stable(idx_i));

endmodule

bind cfg_index_port cip_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
  .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT), .WAIT_IDX(WAIT_IDX),
  .SHADOW_LO(SHADOW_LO), .SHADOW_HI(SHADOW_HI),
  .SYSCTL_IDX(SYSCTL_IDX), .SYSCTL_BIT(SYSCTL_BIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_data_i(wr_data_i),
  .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .regs_o(regs_o),
  .wait_upd_o(wait_upd_o), .shadow_upd_o(shadow_upd_o),
  .sysctl_en_o(sysctl_en_o), .idx_i(cur_idx)
);

// File: tb/tb_cfg_index_port.sv
`timescale 1ns/1ps
module tb_cfg_index_port;

  localparam logic [15:0] IDXP = 16'h0022;
  localparam logic [15:0] DATP = 16'h0023;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  addr = '0;
  logic [7:0]   wdata = '0;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [7:0]   rdata;
  logic [2047:0] regs;
  logic         wait_upd, shadow_upd, sysctl_en;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model [256];
  logic last_wait, last_shadow;

  always #2.5 clk = ~clk;

  cfg_index_port dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_data_i(wdata),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .rd_data_o(rdata), .regs_o(regs),
    .wait_upd_o(wait_upd), .shadow_upd_o(shadow_upd), .sysctl_en_o(sysctl_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_image(input string req);
    int diffs = 0;
    for (int i = 0; i < 256; i++)
      if (regs[i*8 +: 8] !== model[i]) diffs++;
    check(req, diffs, 0);
  endtask

  // write on a falling edge; captured at the following rising edge
  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    last_wait = wait_upd;
    last_shadow = shadow_upd;
  endtask

  task automatic io_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    model[8'h05] = 8'h05;
    model[8'h1B] = 8'h60;
    check_image("R5 image");
    check("R5 wait_upd", wait_upd, 0);
    check("R5 shadow_upd", shadow_upd, 0);
    check("R8 sysctl_en reset", sysctl_en, 0);
    io_rd(DATP, d);
    check("R5 index zero", d, model[0]);
    #1 check("R4 idle bus", rdata, 8'hFF);
  endtask

  task automatic t_index();
    logic [7:0] d;
    io_wr(IDXP, 8'h05);
    check_image("R1 no reg change");
    io_rd(DATP, d);
    check("R3 read reg 05", d, 8'h05);
    io_rd(IDXP, d);
    check("R4 index port read", d, 8'hFF);
    io_rd(16'h0040, d);
    check("R4 foreign addr read", d, 8'hFF);
    io_wr(IDXP, 8'h1B);
    io_rd(DATP, d);
    check("R3 read reg 1B", d, 8'h60);
  endtask

  task automatic t_data();
    logic [7:0] d;
    io_wr(IDXP, 8'h40);
    io_wr(DATP, 8'hA5);
    model[8'h40] = 8'hA5;
    check_image("R2 write 40");
    io_rd(DATP, d);
    check("R9 first read", d, 8'hA5);
    io_wr(DATP, 8'h3C);
    model[8'h40] = 8'h3C;
    io_rd(DATP, d);
    check("R9 second write same idx", d, 8'h3C);
    io_wr(16'h0024, 8'h77);
    check_image("R2 foreign write ignored");
    io_wr(IDXP, 8'hFF);
    io_wr(DATP, 8'h5A);
    model[8'hFF] = 8'h5A;
    check_image("R2 top index");
  endtask

  task automatic t_wait();
    io_wr(IDXP, 8'h06);
    check("R6 index write no strobe", last_wait, 0);
    io_wr(DATP, 8'h11);
    model[8'h06] = 8'h11;
    check("R6 strobe", last_wait, 1);
    check("R7 no shadow on 06", last_shadow, 0);
    @(negedge clk);
    check("R6 strobe one cycle", wait_upd, 0);
    io_wr(IDXP, 8'h07);
    io_wr(DATP, 8'h22);
    model[8'h07] = 8'h22;
    check("R6 no strobe idx 07", last_wait, 0);
    check_image("R2 after wait writes");
  endtask

  task automatic t_shadow();
    for (int i = 8'h17; i <= 8'h1C; i++) begin
      io_wr(IDXP, 8'(i));
      io_wr(DATP, 8'h00);
      model[i] = 8'h00;
      check($sformatf("R7 shadow idx %0h", i), last_shadow,
            (i >= 8'h18 && i <= 8'h1B) ? 1 : 0);
      check($sformatf("R6 quiet idx %0h", i), last_wait, 0);
    end
    @(negedge clk);
    check("R7 strobe one cycle", shadow_upd, 0);
  endtask

  task automatic t_sysctl();
    io_wr(IDXP, 8'h1C);
    io_wr(DATP, 8'h20);
    check("R8 set", sysctl_en, 1);
    io_wr(DATP, 8'hDF);
    check("R8 clear others set", sysctl_en, 0);
    io_wr(DATP, 8'hFF);
    check("R8 set all", sysctl_en, 1);
    io_wr(IDXP, 8'h1D);
    io_wr(DATP, 8'h00);
    check("R8 other reg no effect", sysctl_en, 1);
    io_wr(IDXP, 8'h1C);
    io_wr(DATP, 8'h00);
    check("R8 clear", sysctl_en, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_index();
    t_data();
    t_wait();
    t_shadow();
    t_sysctl();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule